// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It takes a bit clock, a channel-select clock and a serial data line. It recovers one left and one right word per frame and presents each as a 24-bit word with its own single-cycle strobe. The framing is chosen by a 2-bit code on static configuration pins. The code selects one of four formats:

- left-justified,
- the I2S convention with its one-bit delay,
- right-justified with a 16-bit word,
- right-justified with a 24-bit word.

The three serial inputs and the code are brought into the system clock domain through synchronisers. The block works on the rising edges of the bit clock seen there. All four formats share one sliding shift register. Left-aligned formats read the word from the head of the finished slot. Right-aligned formats read it from the tail, so the receiver never needs to know the slot length in advance. A change in the configuration code raises a one-cycle flag for downstream logic. It also discards the framing state, so no word assembled under the old format is delivered under the new one.

Top module: `aud_fmt_rx`

## Requirements
- R1: With code 2'b00 (left-justified), the bit captured on the first bit-clock rising edge after a channel-clock transition is the MSB. A slot with the channel clock high is the left channel.
- R2: With code 2'b01 (I2S), the MSB is captured on the second bit-clock rising edge after a channel-clock transition. The first edge carries the LSB of the previous slot. A slot with the channel clock low is the left channel.
- R3: With code 2'b10, the word is the last 16 bits captured before a channel-clock transition. It is output as {word, 8'h00}. Earlier bits of the slot are ignored. Channel clock high is left.
- R4: With code 2'b11, the word is the last 24 bits captured before a channel-clock transition. Earlier bits of the slot are ignored. Channel clock high is left.
- R5: In the two left-aligned formats, only the first 24 bits of a slot form the word, and later bits in the slot are ignored. A slot shorter than 24 bits gives its bits in the top positions with the remaining low bits zero. Slots of up to 32 bits are supported.
- R6: Each finished slot produces exactly one single-cycle strobe: o_left_vld for the left channel, o_right_vld for the right. The strobe comes one system-clock cycle after the synchronised bit-clock edge that ends the slot. The two strobes are never high together, and the strobes alternate left and right in stream order. Each output word holds until its next strobe.
- R7: When the synchronised configuration code differs from the held code, o_fmt_chg pulses for one cycle. This includes the first capture after reset when the pins are not 2'b00. No strobe accompanies the pulse. The slot in progress, and the first slot boundary after it, deliver nothing.
- R8: During and after synchronous reset, both words are zero and all strobes and the change flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| i_sclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| i_lrck | input | 1 | Channel-select clock marking slot boundaries |
| i_sdata | input | 1 | Serial audio data |
| i_mode | input | 2 | Static framing code: 00 left-justified, 01 I2S, 10 right 16-bit, 11 right 24-bit |
| o_left | output | 24 | Most recent left-channel word |
| o_left_vld | output | 1 | Single-cycle strobe for a new left word |
| o_right | output | 24 | Most recent right-channel word |
| o_right_vld | output | 1 | Single-cycle strobe for a new right word |
| o_fmt_chg | output | 1 | Single-cycle flag on a change of the framing code |

## Verification
Each format is driven with 32-bit slots whose unused bit positions carry non-zero filler. A receiver that reads the wrong window, or misses the I2S one-bit offset, therefore returns a visibly different word. Slots exactly 24 bits long and slots 16 bits long check the boundary where the head and tail windows meet, and the zero fill of short left-aligned slots. Formats are switched both with and without an intervening reset. This separates correct discarding of stale framing state from a receiver that delivers a leftover slot under the new format.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    localparam int WORD_W   = 24;
    localparam int SHORT_W  = 16;
    localparam int SLOT_MAX = 32;
    localparam int CNT_W    = $clog2(SLOT_MAX + 1);
    localparam int PAD_W    = WORD_W - SHORT_W;

    typedef enum logic [1:0] {
        FMT_LJ   = 2'b00,
        FMT_I2S  = 2'b01,
        FMT_RJ16 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    typedef logic [SLOT_MAX-1:0] slot_bits_t;
    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [CNT_W-1:0]    bitcnt_t;

    typedef struct packed {
        logic  is_left;
        word_t word;
    } chan_word_t;

    // Head of a finished slot: n bits, oldest first, left-aligned into a word.
    function automatic word_t align_head(slot_bits_t sh, bitcnt_t n);
        slot_bits_t tmp;
        tmp = sh << (SLOT_MAX - int'(n));
        return tmp[SLOT_MAX-1 -: WORD_W];
    endfunction

    // Tail of a finished slot for the right-aligned codes.
    function automatic word_t align_tail(slot_bits_t sh, fmt_e f);
        if (f == FMT_RJ16)
            return {sh[SHORT_W-1:0], {PAD_W{1'b0}}};
        return sh[WORD_W-1:0];
    endfunction

    function automatic logic is_tail_fmt(fmt_e f);
        return (f == FMT_RJ16) || (f == FMT_RJ24);
    endfunction

    // Channel-clock level that marks the left slot.
    function automatic logic left_level(fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/aud_fmt_sync.sv
module aud_fmt_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/aud_fmt_slot.sv
module aud_fmt_slot
    import aud_fmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    rise,
    input  logic    lrck,
    input  fmt_e    fmt,
    output logic    slot_start,
    output logic    slot_lr,
    output bitcnt_t n_bits,
    output logic    primed
);

    logic seen_q;
    logic lrck_q;
    logic edge_q;
    logic lr_edge;

    // Channel-clock transition between two consecutive bit-clock rises.
    assign lr_edge    = rise & seen_q & (lrck != lrck_q);
    // I2S slots open one bit after the channel-clock transition.
    assign slot_start = (fmt == FMT_I2S) ? (rise & edge_q) : lr_edge;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen_q  <= 1'b0;
            lrck_q  <= 1'b0;
            edge_q  <= 1'b0;
            slot_lr <= 1'b0;
            n_bits  <= '0;
            primed  <= 1'b0;
        end else if (rise) begin
            seen_q <= 1'b1;
            lrck_q <= lrck;
            edge_q <= lr_edge;
            if (slot_start) begin
                n_bits  <= bitcnt_t'(1);
                slot_lr <= lrck;
                primed  <= 1'b1;
            end else if (n_bits != bitcnt_t'(SLOT_MAX)) begin
                n_bits <= n_bits + bitcnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/aud_fmt_shift.sv
module aud_fmt_shift
    import aud_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       sdata,
    output slot_bits_t sh
);

    always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (rise) sh <= {sh[SLOT_MAX-2:0], sdata};
    end

endmodule

// File: rtl/aud_fmt_rx.sv
module aud_fmt_rx
    import aud_fmt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_sclk,
    input  logic              i_lrck,
    input  logic              i_sdata,
    input  logic [1:0]        i_mode,
    output logic [WORD_W-1:0] o_left,
    output logic              o_left_vld,
    output logic [WORD_W-1:0] o_right,
    output logic              o_right_vld,
    output logic              o_fmt_chg
);

    localparam int SYNC_W = 5;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn_in;
    logic              sclk_s, lrck_s, sdata_s;
    fmt_e              mode_s;
    fmt_e              fmt_q;
    logic              sclk_d;
    logic              sclk_rise;
    logic              chg_now;
    logic              slot_start, slot_lr, primed;
    bitcnt_t           n_bits;
    slot_bits_t        sh;
    chan_word_t        fin;
    logic              deliver;

    assign raw_in = {i_mode, i_sdata, i_lrck, i_sclk};

    aud_fmt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign sclk_s  = syn_in[0];
    assign lrck_s  = syn_in[1];
    assign sdata_s = syn_in[2];
    assign mode_s  = fmt_e'(syn_in[4:3]);

    assign sclk_rise = sclk_s & ~sclk_d;
    assign chg_now   = (mode_s != fmt_q);

    aud_fmt_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .clr        (chg_now),
        .rise       (sclk_rise),
        .lrck       (lrck_s),
        .fmt        (fmt_q),
        .slot_start (slot_start),
        .slot_lr    (slot_lr),
        .n_bits     (n_bits),
        .primed     (primed)
    );

    aud_fmt_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .rise  (sclk_rise),
        .sdata (sdata_s),
        .sh    (sh)
    );

    // Word of the slot that the current edge closes (shift register not yet updated).
    always_comb begin
        fin.is_left = (slot_lr == left_level(fmt_q));
        if (is_tail_fmt(fmt_q)) fin.word = align_tail(sh, fmt_q);
        else                    fin.word = align_head(sh, n_bits);
    end

    assign deliver = slot_start & primed & ~chg_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d      <= 1'b0;
            fmt_q       <= FMT_LJ;
            o_fmt_chg   <= 1'b0;
            o_left      <= '0;
            o_right     <= '0;
            o_left_vld  <= 1'b0;
            o_right_vld <= 1'b0;
        end else begin
            sclk_d      <= sclk_s;
            fmt_q       <= mode_s;
            o_fmt_chg   <= chg_now;
            o_left_vld  <= 1'b0;
            o_right_vld <= 1'b0;
            if (deliver) begin
                if (fin.is_left) begin
                    o_left     <= fin.word;
                    o_left_vld <= 1'b1;
                end else begin
                    o_right     <= fin.word;
                    o_right_vld <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/aud_fmt_rx_chk.sv
module aud_fmt_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        left_vld,
    input logic        right_vld,
    input logic        fmt_chg,
    input logic [23:0] left_w,
    input logic [23:0] right_w,
    input logic [1:0]  fmt,
    input logic        rise
);

    // R6
    left_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        left_vld |=> !left_vld);

    // R6
    right_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        right_vld |=> !right_vld);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(left_vld && right_vld));

    // R6
    strobe_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (left_vld || right_vld) |-> $past(rise));

    // R3
    short_left_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (left_vld && fmt == 2'b10) |-> (left_w[7:0] == 8'h00));

    // R3
    short_right_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (right_vld && fmt == 2'b10) |-> (right_w[7:0] == 8'h00));

    // R7
    chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fmt_chg |=> !fmt_chg);

    // R7
    chg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fmt_chg |-> (!left_vld && !right_vld));

endmodule

bind aud_fmt_rx aud_fmt_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .left_vld  (o_left_vld),
    .right_vld (o_right_vld),
    .fmt_chg   (o_fmt_chg),
    .left_w    (o_left),
    .right_w   (o_right),
    .fmt       (fmt_q),
    .rise      (sclk_rise)
);

// File: tb/aud_fmt_rx_bench.sv
module aud_fmt_rx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [23:0] o_left, o_right;
    logic        o_left_vld, o_right_vld, o_fmt_chg;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   chg_seen = 0;
    int   cyc      = 0;
    bit   done     = 1'b0;
    logic prev_d   = 1'b0;
    logic [24:0] exp_q[$];
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    aud_fmt_rx u_aud_fmt_rx (
        .clk         (clk),
        .rst         (rst),
        .i_sclk      (sclk),
        .i_lrck      (lrck),
        .i_sdata     (sdata),
        .i_mode      (mode),
        .o_left      (o_left),
        .o_left_vld  (o_left_vld),
        .o_right     (o_right),
        .o_right_vld (o_right_vld),
        .o_fmt_chg   (o_fmt_chg)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Output monitor, sampled on the falling clock edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (o_fmt_chg) chg_seen++;
            if (o_left_vld || o_right_vld) begin
                if (exp_q.size() == 0) begin
                    check(cur_req, {7'd0, o_left_vld, o_left_vld ? o_left : o_right}, 32'hFFFFFFFF,
                          "R6 unexpected strobe");
                end else begin
                    logic [24:0] e;
                    e = exp_q.pop_front();
                    check(cur_req, {7'd0, o_left_vld, o_left_vld ? o_left : o_right},
                          {7'd0, e}, "R6 channel and word");
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic junk(int i);
        return ((i * 7 + 3) % 5) < 3;
    endfunction

    function automatic logic [23:0] make_word(int seed);
        return 24'h800001 ^ (24'(seed) * 24'h13579B);
    endfunction

    function automatic logic [23:0] expect_word(logic [1:0] f, int s, logic [23:0] w);
        if (f == 2'b10) return {w[15:0], 8'h00};
        if (f == 2'b11) return w;
        if (s >= 24) return w;
        return w & ~((24'h1 << (24 - s)) - 24'h1);
    endfunction

    function automatic logic left_lvl(logic [1:0] f);
        return (f == 2'b01) ? 1'b0 : 1'b1;
    endfunction

    task automatic send_bit(logic lr, logic d);
        @(negedge clk);
        sclk  = 1'b0;
        lrck  = lr;
        if (mode == 2'b01) begin
            sdata  = prev_d;
            prev_d = d;
        end else begin
            sdata = d;
        end
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_slot(logic lr, int s, logic [23:0] w, int salt);
        for (int i = 0; i < s; i++) begin
            logic d;
            d = junk(i + salt);
            case (mode)
                2'b00, 2'b01: if (i < 24) d = w[23 - i];
                2'b10:        if (i >= s - 16) d = w[s - 1 - i];
                default:      if (i >= s - 24) d = w[s - 1 - i];
            endcase
            send_bit(lr, d);
        end
    endtask

    task automatic do_reset(logic [1:0] m, int exp_chg);
        @(negedge clk);
        sclk   = 1'b0;
        rst    = 1'b1;
        mode   = m;
        prev_d = 1'b0;
        repeat (5) @(negedge clk);
        check("R8", {o_left, o_left_vld}, 25'd0, "left state in reset");
        check("R8", {o_right, o_right_vld, o_fmt_chg}, 26'd0, "right state in reset");
        chg_seen = 0;
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check("R7", 32'(chg_seen), 32'(exp_chg), "change flags after reset");
    endtask

    task automatic switch_mode(logic [1:0] m);
        chg_seen = 0;
        @(negedge clk);
        mode   = m;
        prev_d = 1'b0;
        repeat (10) @(negedge clk);
        check("R7", 32'(chg_seen), 32'd1, "change flags on code switch");
    endtask

    // One scenario: lead-in slot, frames, trailing slot.
    task automatic run_stream(string req, int s, int frames, int seed);
        logic ll;
        cur_req = req;
        ll = left_lvl(mode);
        send_slot(~ll, s, make_word(seed + 99), seed);
        for (int k = 0; k < frames; k++) begin
            logic [23:0] wl, wr;
            wl = make_word(seed + 2 * k);
            wr = make_word(seed + 2 * k + 1);
            exp_q.push_back({1'b1, expect_word(mode, s, wl)});
            exp_q.push_back({1'b0, expect_word(mode, s, wr)});
            send_slot(ll, s, wl, seed + k);
            send_slot(~ll, s, wr, seed + k + 5);
        end
        send_slot(ll, s, make_word(seed + 77), seed + 3);
        repeat (20) @(negedge clk);
        check(req, 32'(exp_q.size()), 32'd0, "R6 words outstanding at end");
        exp_q.delete();
    endtask

    task automatic test_lj_wide();
        do_reset(2'b00, 0);
        run_stream("R1", 32, 3, 10);
    endtask

    task automatic test_i2s_wide();
        switch_mode(2'b01);
        run_stream("R2", 32, 3, 20);
    endtask

    task automatic test_rj16_wide();
        switch_mode(2'b10);
        run_stream("R3", 32, 3, 30);
    endtask

    task automatic test_rj24_wide();
        switch_mode(2'b11);
        run_stream("R4", 32, 3, 40);
    endtask

    task automatic test_lj_short();
        do_reset(2'b00, 0);
        run_stream("R5", 16, 3, 50);
    endtask

    task automatic test_rj24_exact();
        switch_mode(2'b11);
        run_stream("R4", 24, 2, 60);
    endtask

    task automatic test_i2s_exact();
        switch_mode(2'b01);
        run_stream("R5", 24, 2, 70);
    endtask

    task automatic test_rj16_after_reset();
        do_reset(2'b10, 1);
        run_stream("R3", 16, 2, 80);
    endtask

    initial begin
        test_lj_wide();
        test_i2s_wide();
        test_rj16_wide();
        test_rj24_wide();
        test_lj_short();
        test_rj24_exact();
        test_i2s_exact();
        test_rj16_after_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule